// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block performs one register write into the configuration test port of a high-speed serial PHY. The port has four pins: a clear line, a strobe, an enable, and an 8-bit bus that carries both the test code and the data byte. A write always takes eight fixed steps. First the port is cleared and the strobe is primed high. Next the code is placed on the bus with enable high, and the strobe falls so the PHY captures the code. Then the data byte is placed on the bus with enable low, and the strobe rises so the PHY captures the data. Finally the strobe returns low. Each step holds its pin values for a programmable number of clock cycles, which gives the PHY its setup and hold margins.

There are two ways to request a write. A direct request carries a code, a data byte and a start pulse. A rate request carries the link frequency in Hz and a flag that says whether that frequency is valid. For a rate request, the block works out the per-lane bit rate and finds the matching frequency-range byte. It then writes that byte to test code 0x44. If the rate is outside the table, the block pulses an error output and leaves the test pins untouched.

Top module: `phy_tst_writer`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, busy_o, done_o and err_o are 0, and tst_clr_o, tst_stb_o, tst_en_o and tst_bus_o are all 0.
- R2: An accepted request drives eight steps in this order, written as {clr,stb,en,bus}: {1,0,0,0}, {0,0,0,0}, {0,1,0,0}, {0,1,1,code}, {0,0,1,code}, {0,0,0,data}, {0,1,0,data}, {0,0,0,data}. Steps begin in the cycle after the accepting clock edge.
- R3: The code is presented with enable high while the strobe is high. In the next step the strobe falls, and enable and the bus do not change in that same cycle.
- R4: The data byte is presented with enable low while the strobe is low. In the next step the strobe rises, and the bus does not change in that same cycle.
- R5: Each step lasts N cycles. N is the value of step_cycles_i captured when the request is accepted, and a value of 0 counts as 1. Changing step_cycles_i during a transaction has no effect on it.
- R6: busy_o is high during exactly the 8·N step cycles. done_o is high for exactly one cycle, the cycle right after the last step. In that cycle busy_o is 0 and all test pins are 0.
- R7: A start_i or rate_start_i that arrives while busy_o is high is ignored. If start_i and rate_start_i are high in the same idle cycle, the direct request wins.
- R8: A rate request writes code 0x44. Its data byte comes from the first entry, scanned in ascending order of limit, whose limit is strictly greater than the rate in Mbps. The entries, as limit:byte pairs, are 90:00 100:20 110:40 125:02 140:22 150:42 160:04 180:24 200:44 210:06 240:26 250:46 270:08 300:28 330:48 360:2a 400:4a 450:0c 500:2c 550:0e 600:2e 650:10 700:30 750:12 800:32 850:14 900:34 950:54 1000:74.
- R9: The rate in Mbps is ceil(2·link_freq_i / 1,000,000). When link_vld_i is 0, a rate of 849 Mbps is used, which gives byte 0x14.
- R10: A rate of 1000 Mbps or more raises err_o for exactly one cycle, the cycle after the request. busy_o stays 0 and no test pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Direct write request pulse |
| code_i | input | 8 | Test code for a direct write |
| data_i | input | 8 | Data byte for a direct write |
| rate_start_i | input | 1 | Frequency-range write request pulse |
| link_vld_i | input | 1 | link_freq_i is valid |
| link_freq_i | input | 32 | Link frequency in Hz |
| step_cycles_i | input | 8 | Cycles per step (0 is treated as 1) |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | One-cycle rate-lookup failure pulse |
| tst_clr_o | output | 1 | PHY test clear line |
| tst_stb_o | output | 1 | PHY test strobe |
| tst_en_o | output | 1 | PHY test enable (high: code, low: data) |
| tst_bus_o | output | 8 | Shared code/data bus |

## Verification
The hardest cases to reach are the exact edges of the rate table, where one extra Hz moves the result to the next byte or into the error path. The bench drives every table limit at (limit−1)·500,000 Hz and at one Hz more. For each case it computes the expected byte with its own ceiling division and table scan. A second hard case is a start pulse injected in the middle of a transaction, together with a changed step_cycles_i. The bench issues both during a live write. It then checks that the cycle-by-cycle pin trace is unchanged and that no second transaction follows done.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;

  localparam int unsigned TST_W       = 8;
  localparam int unsigned RANGE_N     = 29;
  localparam logic [7:0]  RANGE_CODE  = 8'h44;
  localparam int unsigned DEF_MBPS    = 849;
  localparam longint unsigned HZ_PER_MBPS = 64'd500000; // rate = ceil(f / 500000)

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR,
    ST_REL,
    ST_STB_HI,
    ST_CODE,
    ST_CODE_LAT,
    ST_DATA,
    ST_DATA_LAT,
    ST_END
  } tst_step_e;

  typedef struct packed {
    logic             clr;
    logic             stb;
    logic             en;
    logic [TST_W-1:0] bus;
  } tst_pins_t;

  function automatic int unsigned range_max(input int idx);
    case (idx)
      0: return 90;    1: return 100;   2: return 110;   3: return 125;
      4: return 140;   5: return 150;   6: return 160;   7: return 180;
      8: return 200;   9: return 210;   10: return 240;  11: return 250;
      12: return 270;  13: return 300;  14: return 330;  15: return 360;
      16: return 400;  17: return 450;  18: return 500;  19: return 550;
      20: return 600;  21: return 650;  22: return 700;  23: return 750;
      24: return 800;  25: return 850;  26: return 900;  27: return 950;
      default: return 1000;
    endcase
  endfunction

  function automatic logic [7:0] range_sel(input int idx);
    case (idx)
      0: return 8'h00;  1: return 8'h20;  2: return 8'h40;  3: return 8'h02;
      4: return 8'h22;  5: return 8'h42;  6: return 8'h04;  7: return 8'h24;
      8: return 8'h44;  9: return 8'h06;  10: return 8'h26; 11: return 8'h46;
      12: return 8'h08; 13: return 8'h28; 14: return 8'h48; 15: return 8'h2a;
      16: return 8'h4a; 17: return 8'h0c; 18: return 8'h2c; 19: return 8'h0e;
      20: return 8'h2e; 21: return 8'h10; 22: return 8'h30; 23: return 8'h12;
      24: return 8'h32; 25: return 8'h14; 26: return 8'h34; 27: return 8'h54;
      default: return 8'h74;
    endcase
  endfunction

endpackage

// File: rtl/rate_range_lut.sv
module rate_range_lut
  import phy_tst_pkg::*;
#(
  parameter int unsigned FREQ_W = 32
) (
  input  logic              vld_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [7:0]        sel_o,
  output logic              err_o
);

  logic [RANGE_N-1:0] hit;
  logic [63:0]        freq_z;

  assign freq_z = 64'(freq_i);

  // ceil(f/500000) < M  <=>  f <= (M-1)*500000 : no divider needed
  for (genvar gi = 0; gi < RANGE_N; gi++) begin : g_ent
    localparam logic [63:0] LIM = 64'(range_max(gi) - 1) * HZ_PER_MBPS;
    localparam logic        DEF_HIT = (DEF_MBPS < range_max(gi));
    assign hit[gi] = vld_i ? (freq_z <= LIM) : DEF_HIT;
  end

  always_comb begin
    sel_o = '0;
    err_o = 1'b1;
    for (int i = RANGE_N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_o = range_sel(i);
        err_o = 1'b0;
      end
    end
  end

endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tst_seq_fsm.sv
module tst_seq_fsm
  import phy_tst_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [TST_W-1:0] code_i,
  input  logic [TST_W-1:0] data_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             busy_o,
  output logic             done_o,
  output tst_pins_t        pins_o
);

  tst_step_e        step_q;
  logic [TST_W-1:0] code_q, data_q;
  logic [CNT_W-1:0] hold_q;
  logic             done_q;
  logic             step_end;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  assign busy_o   = (step_q != ST_IDLE);
  assign step_end = busy_o && tmr_zero;
  assign tmr_load = go_i || (step_end && step_q != ST_END);
  assign tmr_val  = go_i ? (hold_i - 1'b1) : (hold_q - 1'b1);

  logic tmr_zero;

  step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      code_q <= '0;
      data_q <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        step_q <= ST_CLR;
        code_q <= code_i;
        data_q <= data_i;
        hold_q <= hold_i;
      end else if (step_end) begin
        if (step_q == ST_END) begin
          step_q <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          step_q <= tst_step_e'(step_q + 4'd1);
        end
      end
    end
  end

  assign done_o = done_q;

  always_comb begin
    pins_o = '0;
    unique case (step_q)
      ST_CLR:      pins_o.clr = 1'b1;
      ST_STB_HI:   pins_o.stb = 1'b1;
      ST_CODE:     begin pins_o.stb = 1'b1; pins_o.en = 1'b1; pins_o.bus = code_q; end
      ST_CODE_LAT: begin pins_o.en = 1'b1;  pins_o.bus = code_q; end
      ST_DATA:     pins_o.bus = data_q;
      ST_DATA_LAT: begin pins_o.stb = 1'b1; pins_o.bus = data_q; end
      ST_END:      pins_o.bus = data_q;
      default:     pins_o = '0;
    endcase
  end

endmodule

// File: rtl/phy_tst_writer.sv
module phy_tst_writer
  import phy_tst_pkg::*;
#(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        code_i,
  input  logic [7:0]        data_i,
  input  logic              rate_start_i,
  input  logic              link_vld_i,
  input  logic [FREQ_W-1:0] link_freq_i,
  input  logic [CNT_W-1:0]  step_cycles_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              tst_clr_o,
  output logic              tst_stb_o,
  output logic              tst_en_o,
  output logic [7:0]        tst_bus_o
);

  logic             lut_err;
  logic [7:0]       lut_sel;
  logic             go_direct, go_rate, launch;
  logic [7:0]       go_code, go_data;
  logic [CNT_W-1:0] hold_eff;
  logic             err_q;
  tst_pins_t        pins;

  rate_range_lut #(.FREQ_W(FREQ_W)) u_lut (
    .vld_i  (link_vld_i),
    .freq_i (link_freq_i),
    .sel_o  (lut_sel),
    .err_o  (lut_err)
  );

  assign go_direct = start_i && !busy_o;
  assign go_rate   = rate_start_i && !start_i && !busy_o;
  assign launch    = go_direct || (go_rate && !lut_err);
  assign go_code   = go_direct ? code_i : RANGE_CODE;
  assign go_data   = go_direct ? data_i : lut_sel;
  assign hold_eff  = (step_cycles_i == '0) ? CNT_W'(1) : step_cycles_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= go_rate && lut_err;
  end

  tst_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (launch),
    .code_i (go_code),
    .data_i (go_data),
    .hold_i (hold_eff),
    .busy_o (busy_o),
    .done_o (done_o),
    .pins_o (pins)
  );

  assign err_o     = err_q;
  assign tst_clr_o = pins.clr;
  assign tst_stb_o = pins.stb;
  assign tst_en_o  = pins.en;
  assign tst_bus_o = pins.bus;

endmodule

// File: rtl/phy_tst_writer_chk.sv
module phy_tst_writer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       rate_start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       tst_clr_o,
  input logic       tst_stb_o,
  input logic       tst_en_o,
  input logic [7:0] tst_bus_o
);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tst_clr_o && !tst_stb_o && !tst_en_o && tst_bus_o == 8'h00));

  a_r2_begins_with_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> tst_clr_o);

  a_r2_clear_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_clr_o |-> (!tst_stb_o && !tst_en_o && tst_bus_o == 8'h00));

  a_r3_code_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tst_stb_o) && tst_en_o) |-> ($stable(tst_bus_o) && $stable(tst_en_o)));

  a_r4_data_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tst_stb_o) |-> (!tst_en_o && $stable(tst_bus_o)));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (start_i || rate_start_i)) |=> (busy_o || done_o));

  a_r10_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !tst_clr_o && !tst_stb_o));

  a_r10_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

endmodule

bind phy_tst_writer phy_tst_writer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .rate_start_i (rate_start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .tst_clr_o    (tst_clr_o),
  .tst_stb_o    (tst_stb_o),
  .tst_en_o     (tst_en_o),
  .tst_bus_o    (tst_bus_o)
);

// File: tb/phy_tst_writer_bench.sv
module phy_tst_writer_bench;

  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  code_i = '0;
  logic [7:0]  data_i = '0;
  logic        rate_start_i = 1'b0;
  logic        link_vld_i = 1'b0;
  logic [31:0] link_freq_i = '0;
  logic [7:0]  step_cycles_i = 8'd1;
  logic        busy_o, done_o, err_o, tst_clr_o, tst_stb_o, tst_en_o;
  logic [7:0]  tst_bus_o;

  int total = 0;
  int bad = 0;
  bit fin = 0;

  int unsigned lim_t [29];
  logic [7:0]  sel_t [29];

  always #(CLK_P/2) clk_i = ~clk_i;

  phy_tst_writer u_phy_tst_writer (
    .clk_i, .rst_ni, .start_i, .code_i, .data_i, .rate_start_i,
    .link_vld_i, .link_freq_i, .step_cycles_i,
    .busy_o, .done_o, .err_o, .tst_clr_o, .tst_stb_o, .tst_en_o, .tst_bus_o
  );

  function automatic logic [10:0] pins_now();
    return {tst_clr_o, tst_stb_o, tst_en_o, tst_bus_o};
  endfunction

  // expected {clr,stb,en,bus} for step s
  function automatic logic [10:0] exp_step(input int s, input logic [7:0] c, input logic [7:0] d);
    case (s)
      0: return {3'b100, 8'h00};
      1: return {3'b000, 8'h00};
      2: return {3'b010, 8'h00};
      3: return {3'b011, c};
      4: return {3'b001, c};
      5: return {3'b000, d};
      6: return {3'b010, d};
      default: return {3'b000, d};
    endcase
  endfunction

  function automatic string step_req(input int s);
    if (s == 3 || s == 4) return "R3 R5";
    if (s == 5 || s == 6) return "R4 R5";
    return "R2 R5";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // expected byte: -1 on error
  function automatic int exp_sel(input logic [31:0] f, input logic v);
    longint unsigned mbps;
    mbps = v ? ((2 * longint'(f) + 64'd999999) / 64'd1000000) : 64'd849;
    for (int i = 0; i < 29; i++)
      if (lim_t[i] > mbps) return int'(sel_t[i]);
    return -1;
  endfunction

  // kind 0: direct, 1: rate, 2: both at once
  task automatic do_txn(input int kind, input logic [7:0] c, input logic [7:0] d,
                        input logic [31:0] f, input logic fv, input logic [7:0] hp,
                        input logic [7:0] ec, input logic [7:0] ed, input int inj);
    int n;
    n = (hp == 0) ? 1 : int'(hp);
    code_i = c; data_i = d; link_freq_i = f; link_vld_i = fv; step_cycles_i = hp;
    start_i = (kind != 1);
    rate_start_i = (kind != 0);
    @(negedge clk_i);
    start_i = 0; rate_start_i = 0;
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < n; k++) begin
        chk(pins_now() == exp_step(s, ec, ed) && busy_o, step_req(s),
            {20'h0, busy_o, pins_now()}, {20'h1, exp_step(s, ec, ed)});
        if (s * n + k == inj) begin
          start_i = 1; rate_start_i = 1; code_i = ~c; step_cycles_i = hp + 8'd3;
        end
        @(negedge clk_i);
        start_i = 0; rate_start_i = 0;
      end
    end
    chk(done_o && !busy_o && pins_now() == 11'h0, "R6 done",
        {busy_o, done_o, pins_now()}, {2'b01, 11'h0});
    @(negedge clk_i);
    chk(!done_o, "R6 done width", done_o, 0);
    if (inj >= 0) begin
      chk(!busy_o, "R7 ignored start", busy_o, 0);
      @(negedge clk_i);
      chk(!busy_o && pins_now() == 11'h0, "R7 no replay", {busy_o, pins_now()}, 0);
    end
  endtask

  task automatic do_err(input logic [31:0] f);
    link_freq_i = f; link_vld_i = 1; rate_start_i = 1;
    @(negedge clk_i);
    rate_start_i = 0;
    chk(err_o && !busy_o && pins_now() == 11'h0, "R10 err pulse",
        {err_o, busy_o, pins_now()}, {2'b10, 11'h0});
    @(negedge clk_i);
    chk(!err_o && !busy_o && pins_now() == 11'h0, "R10 err end quiet",
        {err_o, busy_o, pins_now()}, 0);
  endtask

  initial begin
    lim_t = '{90,100,110,125,140,150,160,180,200,210,240,250,270,300,330,
              360,400,450,500,550,600,650,700,750,800,850,900,950,1000};
    sel_t = '{8'h00,8'h20,8'h40,8'h02,8'h22,8'h42,8'h04,8'h24,8'h44,8'h06,
              8'h26,8'h46,8'h08,8'h28,8'h48,8'h2a,8'h4a,8'h0c,8'h2c,8'h0e,
              8'h2e,8'h10,8'h30,8'h12,8'h32,8'h14,8'h34,8'h54,8'h74};
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && pins_now() == 11'h0, "R1 in reset",
        {busy_o, done_o, err_o, pins_now()}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && pins_now() == 11'h0, "R1 after reset",
        {busy_o, done_o, err_o, pins_now()}, 0);

    // direct writes over hold values and patterns
    for (int h = 0; h < 5; h++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] c, d;
        c = 8'(8'h11 * (p + 1) + h);
        d = ~c ^ 8'(p << 4);
        do_txn(0, c, d, 0, 0, 8'(h), c, d, -1);
      end
    end
    do_txn(0, 8'hFF, 8'h00, 0, 0, 8'd2, 8'hFF, 8'h00, -1);
    do_txn(0, 8'h00, 8'hFF, 0, 0, 8'd1, 8'h00, 8'hFF, -1);

    // R7: start during busy, and step_cycles change mid-flight (R5)
    do_txn(0, 8'h3C, 8'hC3, 0, 0, 8'd2, 8'h3C, 8'hC3, 5);
    do_txn(0, 8'h5A, 8'hA6, 0, 0, 8'd1, 8'h5A, 8'hA6, 0);
    // R7: direct request wins over rate request in the same cycle
    do_txn(2, 8'h5A, 8'hA5, 32'd100_000_000, 1, 8'd1, 8'h5A, 8'hA5, -1);

    // R9: no valid frequency uses the default rate
    do_txn(1, 8'h00, 8'h00, 32'hFFFF_FFFF, 0, 8'd1, 8'h44, 8'(exp_sel(0, 0)), -1);
    chk(exp_sel(0, 0) == 8'h14, "R9 default byte", exp_sel(0, 0), 8'h14);

    // R8 R9: both sides of each table limit
    for (int i = 0; i < 29; i++) begin
      logic [31:0] f0, f1;
      int e0, e1;
      f0 = 32'((lim_t[i] - 1) * 500000);
      f1 = f0 + 1;
      e0 = exp_sel(f0, 1);
      e1 = exp_sel(f1, 1);
      chk(e0 >= 0, "R8 table scan", e0, 0);
      do_txn(1, 8'h00, 8'h00, f0, 1, 8'd1, 8'h44, 8'(e0), -1);
      if (e1 < 0) do_err(f1);
      else do_txn(1, 8'h00, 8'h00, f1, 1, 8'd1, 8'h44, 8'(e1), -1);
    end
    do_txn(1, 8'h00, 8'h00, 32'd0, 1, 8'd3, 8'h44, 8'h00, -1);

    // R10: out-of-range rates
    do_err(32'd500_000_000);
    do_err(32'hFFFF_FFFF);
    do_txn(0, 8'h12, 8'h34, 0, 0, 8'd1, 8'h12, 8'h34, -1);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule